// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Controller

This block is the digital half of a 12-bit successive-approximation converter that hangs off an 8-bit microprocessor bus. A single group of active-low strobes (select, read, write) and two address-like inputs (byte choice and register choice) carry every host action. These actions are: starting a conversion, reading either byte of the result, writing or reading an 8-bit control register, and, through a separate pin, starting a calibration period. The data bus is tri-state, shown as a split pair of input and output with an output-enable.

Once a conversion starts, the sequencer first holds for a fixed acquisition window. It then resolves one bit per clock, MSB first, using an external comparator that reports whether the analog input is at or above the level of the trial code it drives out. A busy flag, active low, covers the whole conversion or calibration, and any start that arrives while it is low is dropped. Setting bit 2 of the control register changes the calibration pin into a sample/hold control. While that pin is high the input is being sampled, and its falling edge begins the bit decisions straight away.

Top module: `sar_busctl`

## Requirements
- R1: After reset, busy is high (idle), the data bus is not driven, the result reads 0 in both bytes and the control register reads 0x00.
- R2: While select is high, the data bus is not driven, and the read, write and register-select strobes neither start a conversion nor change the control register.
- R3: With select low and register-select low, a low-to-high write transition (read held high) starts a conversion. Busy goes low from the clock edge that sees the transition and stays low for exactly 5 acquisition plus 12 decision clocks, 17 clocks in all.
- R4: The sequencer drives the trial code MSB first and keeps each trial bit when the comparator input is 1 (input at or above the trial level). The stored result therefore equals the largest code not above the input level.
- R5: With select and read low, write high and register-select low, the bus is driven. Byte-select 0 returns result bits 7:0, and byte-select 1 returns result bits 11:8 in bus bits 3:0 with bus bits 7:4 at zero.
- R6: The result register changes only at the end of the last decision. A read during a conversion returns the previous result.
- R7: With register-select high and byte-select 0, a low-to-high write transition loads the control register from the data bus. If bit 2 was clear before that write, the same transition starts a conversion. A read with register-select high and byte-select 0 returns the control register.
- R8: While busy is low, write starts and calibration-pin edges are ignored. The running operation keeps its length and result, and no second busy period follows.
- R9: With control bit 2 clear, a rising edge on the calibration pin holds busy low for exactly CAL_CYCLES clocks (40 by default) and leaves the result unchanged.
- R10: With control bit 2 set, bus writes do not start conversions and a rising pin edge does not calibrate. A falling pin edge starts the 12 decision clocks directly, with no acquisition window, so busy is low for 12 clocks.
- R11: Reserved combinations are read and write both low, or register-select and byte-select both high. A reserved read drives 0x00 onto the bus. A reserved write starts nothing and leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion and bus sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low; its rising edge acts |
| byte_hi | input | 1 | Result byte choice: 0 low byte, 1 high byte |
| reg_sel | input | 1 | 1 selects the control register instead of the result |
| cal_hold | input | 1 | Calibration start, or sample/hold control when control bit 2 is set |
| cmp_ge | input | 1 | Comparator: 1 when the input is at or above the trial level |
| data_in | input | 8 | Bus data written by the host |
| data_out | output | 8 | Bus data returned to the host |
| data_oe | output | 1 | Bus drive enable; 0 means high impedance |
| conv_busy_n | output | 1 | Low while a conversion or calibration runs |
| dac_code | output | 12 | Trial code for the comparison DAC |

## Verification
The bench sweeps input levels across the full 12-bit range, including both ends and the codes on either side of the midpoint. An inverted comparator sense or an off-by-one in the bit index would garble the result there. It counts busy lengths in the normal, sample/hold and calibration paths, so an acquisition window that is one clock too long or too short, or one applied in sample/hold mode, shows up as a wrong count. It reads the result in the middle of a conversion, which catches a result register that is updated bit by bit. It issues starts while busy and writes that leave sample/hold mode, and a design that re-triggers there produces an extra busy period. Reserved strobe patterns are checked for a zero bus value and an unchanged control register.

// File: rtl/sar_busctl_pkg.sv
// Shared types for the converter bus controller.
// Assumes the control register is wider than the mode bit index.
package sar_busctl_pkg;

    // Sequencer phases.
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ACQ,
        SEQ_DEC,
        SEQ_CAL
    } seq_state_e;

    // What the bus read path returns.
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LO,
        SRC_HI,
        SRC_CTL,
        SRC_RSVD
    } rd_src_e;

    // Control register bit that turns the calibration pin into sample/hold control.
    localparam int SHC_MODE_BIT = 2;

endpackage

// File: rtl/sar_bus_decode.sv
// Strobe decoder: detects write and pin edges, owns the control register,
// and picks the read source. Assumes strobes are already synchronous to clk.
module sar_bus_decode
    import sar_busctl_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs_n,
    input  logic             bus_rd_n,
    input  logic             bus_wr_n,
    input  logic             byte_hi,
    input  logic             reg_sel,
    input  logic             cal_hold,
    input  logic [BUS_W-1:0] data_in,
    output logic [BUS_W-1:0] ctl_q,
    output rd_src_e          rd_src,
    output logic             conv_req,
    output logic             cal_req,
    output logic             shc_req
);

    logic wr_q;
    logic pin_q;
    logic selected;
    logic rsvd;
    logic wr_rise;
    logic shc_mode;

    // Remember previous strobe and pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= 1'b1;
            pin_q <= cal_hold;
        end else begin
            wr_q  <= bus_wr_n;
            pin_q <= cal_hold;
        end
    end

    // Combinational decode of the strobe pattern.
    always_comb begin
        selected = !bus_cs_n;
        rsvd     = (!bus_rd_n && !bus_wr_n) || (reg_sel && byte_hi);
        wr_rise  = selected && bus_wr_n && !wr_q && bus_rd_n && !(reg_sel && byte_hi);
        shc_mode = ctl_q[SHC_MODE_BIT];
    end

    // Control register load on a valid register write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_rise && reg_sel) begin
            ctl_q <= data_in;
        end
    end

    // Start requests; the mode used is the one held before any write in this cycle.
    always_comb begin
        conv_req = wr_rise && !shc_mode;
        cal_req  = cal_hold && !pin_q && !shc_mode;
        shc_req  = !cal_hold && pin_q && shc_mode;
    end

    // Read source selection.
    always_comb begin
        if (!selected || bus_rd_n) begin
            rd_src = SRC_NONE;
        end else if (rsvd) begin
            rd_src = SRC_RSVD;
        end else if (reg_sel) begin
            rd_src = SRC_CTL;
        end else if (byte_hi) begin
            rd_src = SRC_HI;
        end else begin
            rd_src = SRC_LO;
        end
    end

endmodule

// File: rtl/sar_seq.sv
// Successive-approximation sequencer: acquisition window, one bit decision
// per clock MSB first, fixed-length calibration. Starts are taken only in idle.
// Assumes ACQ_CYCLES and CAL_CYCLES are at least 1.
module sar_seq
    import sar_busctl_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int ACQ_CYCLES = 5,
    parameter int CAL_CYCLES = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_req,
    input  logic             cal_req,
    input  logic             shc_req,
    input  logic             cmp_ge,
    output logic             busy_n,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);

    localparam int IDX_W   = $clog2(RES_W);
    localparam int CNT_MAX = (ACQ_CYCLES > CAL_CYCLES) ? ACQ_CYCLES : CAL_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);
    localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYCLES - 1);
    localparam logic [CNT_W-1:0] CAL_LAST = CNT_W'(CAL_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [RES_W-1:0] trial_q, trial_d;
    logic [RES_W-1:0] res_q, res_d;

    // Next-state and datapath for each sequencer phase.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        trial_d = trial_q;
        res_d   = res_q;
        case (state_q)
            SEQ_IDLE: begin
                if (cal_req) begin
                    state_d = SEQ_CAL;
                    cnt_d   = '0;
                end else if (shc_req) begin
                    state_d = SEQ_DEC;
                    idx_d   = IDX_TOP;
                    trial_d = MSB_ONE;
                end else if (conv_req) begin
                    state_d = SEQ_ACQ;
                    cnt_d   = '0;
                end
            end
            SEQ_ACQ: begin
                if (cnt_q == ACQ_LAST) begin
                    state_d = SEQ_DEC;
                    idx_d   = IDX_TOP;
                    trial_d = MSB_ONE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            SEQ_DEC: begin
                trial_d[idx_q] = cmp_ge;
                if (idx_q == '0) begin
                    res_d   = trial_d;
                    trial_d = '0;
                    state_d = SEQ_IDLE;
                end else begin
                    trial_d[idx_q - IDX_W'(1)] = 1'b1;
                    idx_d = idx_q - IDX_W'(1);
                end
            end
            SEQ_CAL: begin
                if (cnt_q == CAL_LAST) begin
                    state_d = SEQ_IDLE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            trial_q <= '0;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            trial_q <= trial_d;
            res_q   <= res_d;
        end
    end

    // Outputs straight from state.
    always_comb begin
        busy_n   = (state_q == SEQ_IDLE);
        dac_code = trial_q;
        result   = res_q;
    end

endmodule

// File: rtl/sar_rdmux.sv
// Read multiplexer: places a result byte, the control register or zero on the bus.
// Assumes BUS_W < RES_W < 2*BUS_W, so the high byte is zero-padded.
module sar_rdmux
    import sar_busctl_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int BUS_W = 8
) (
    input  rd_src_e          rd_src,
    input  logic [RES_W-1:0] result,
    input  logic [BUS_W-1:0] ctl_q,
    output logic [BUS_W-1:0] data_out,
    output logic             data_oe
);

    localparam int HI_W = RES_W - BUS_W;
    localparam int PAD_W = BUS_W - HI_W;

    logic [BUS_W-1:0] lo_byte;
    logic [BUS_W-1:0] hi_byte;

    // Split the result into bus-sized pieces.
    always_comb begin
        lo_byte = result[BUS_W-1:0];
        hi_byte = {{PAD_W{1'b0}}, result[RES_W-1:BUS_W]};
    end

    // Source select and drive enable.
    always_comb begin
        data_oe = (rd_src != SRC_NONE);
        case (rd_src)
            SRC_LO:  data_out = lo_byte;
            SRC_HI:  data_out = hi_byte;
            SRC_CTL: data_out = ctl_q;
            default: data_out = '0;
        endcase
    end

endmodule

// File: rtl/sar_busctl.sv
// Top of the converter bus controller: strobe decoder, sequencer and read path.
// Assumes all inputs are synchronous to clk.
module sar_busctl
    import sar_busctl_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int BUS_W      = 8,
    parameter int ACQ_CYCLES = 5,
    parameter int CAL_CYCLES = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs_n,
    input  logic             bus_rd_n,
    input  logic             bus_wr_n,
    input  logic             byte_hi,
    input  logic             reg_sel,
    input  logic             cal_hold,
    input  logic             cmp_ge,
    input  logic [BUS_W-1:0] data_in,
    output logic [BUS_W-1:0] data_out,
    output logic             data_oe,
    output logic             conv_busy_n,
    output logic [RES_W-1:0] dac_code
);

    logic [BUS_W-1:0] ctl_q;
    logic [RES_W-1:0] res_q;
    rd_src_e          rd_src;
    logic             conv_req;
    logic             cal_req;
    logic             shc_req;

    sar_bus_decode #(.BUS_W(BUS_W)) decode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cs_n (bus_cs_n),
        .bus_rd_n (bus_rd_n),
        .bus_wr_n (bus_wr_n),
        .byte_hi  (byte_hi),
        .reg_sel  (reg_sel),
        .cal_hold (cal_hold),
        .data_in  (data_in),
        .ctl_q    (ctl_q),
        .rd_src   (rd_src),
        .conv_req (conv_req),
        .cal_req  (cal_req),
        .shc_req  (shc_req)
    );

    sar_seq #(
        .RES_W      (RES_W),
        .ACQ_CYCLES (ACQ_CYCLES),
        .CAL_CYCLES (CAL_CYCLES)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_req (conv_req),
        .cal_req  (cal_req),
        .shc_req  (shc_req),
        .cmp_ge   (cmp_ge),
        .busy_n   (conv_busy_n),
        .dac_code (dac_code),
        .result   (res_q)
    );

    sar_rdmux #(.RES_W(RES_W), .BUS_W(BUS_W)) rdmux_i (
        .rd_src   (rd_src),
        .result   (res_q),
        .ctl_q    (ctl_q),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

endmodule

// File: rtl/sar_busctl_chk.sv
// Property checker for the bus controller, bound to the top module.
// Assumes reset is asserted at time zero.
module sar_busctl_chk #(
    parameter int RES_W      = 12,
    parameter int BUS_W      = 8,
    parameter int ACQ_CYCLES = 5,
    parameter int CAL_CYCLES = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_cs_n,
    input logic             bus_rd_n,
    input logic             bus_wr_n,
    input logic             byte_hi,
    input logic             reg_sel,
    input logic [BUS_W-1:0] data_in,
    input logic [BUS_W-1:0] data_out,
    input logic             data_oe,
    input logic             conv_busy_n,
    input logic [BUS_W-1:0] ctl_q,
    input logic [RES_W-1:0] res_q
);

    logic [15:0] low_len;

    // Length of the current busy-low run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_len <= '0;
        end else if (!conv_busy_n) begin
            low_len <= low_len + 16'd1;
        end else begin
            low_len <= '0;
        end
    end

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> !data_oe);

    // R3 R9 R10
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_busy_n) |-> (low_len == 16'(ACQ_CYCLES + RES_W)
                               || low_len == 16'(RES_W)
                               || low_len == 16'(CAL_CYCLES)));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy_n |=> $stable(res_q));

    // R7
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && reg_sel && !byte_hi && bus_rd_n && $rose(bus_wr_n))
        |=> (ctl_q == $past(data_in)));

    // R11
    rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !bus_rd_n && (!bus_wr_n || (reg_sel && byte_hi)))
        |-> (data_oe && data_out == '0));

endmodule

bind sar_busctl sar_busctl_chk #(
    .RES_W      (RES_W),
    .BUS_W      (BUS_W),
    .ACQ_CYCLES (ACQ_CYCLES),
    .CAL_CYCLES (CAL_CYCLES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_cs_n    (bus_cs_n),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .byte_hi     (byte_hi),
    .reg_sel     (reg_sel),
    .data_in     (data_in),
    .data_out    (data_out),
    .data_oe     (data_oe),
    .conv_busy_n (conv_busy_n),
    .ctl_q       (ctl_q),
    .res_q       (res_q)
);

// File: tb/sar_busctl_tb_top.sv
`timescale 1ns/100ps
// Self-checking bench: sweeps input levels through an ideal comparator model
// and exercises every strobe pattern and mode.
module sar_busctl_tb_top;

    localparam int RES_W = 12;
    localparam int BUS_W = 8;
    localparam int ACQ   = 5;
    localparam int CAL   = 40;
    localparam int NORM_LEN = ACQ + RES_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_cs_n = 1'b1;
    logic             bus_rd_n = 1'b1;
    logic             bus_wr_n = 1'b1;
    logic             byte_hi = 1'b0;
    logic             reg_sel = 1'b0;
    logic             cal_hold = 1'b0;
    logic             cmp_ge;
    logic [BUS_W-1:0] data_in = '0;
    logic [BUS_W-1:0] data_out;
    logic             data_oe;
    logic             conv_busy_n;
    logic [RES_W-1:0] dac_code;
    logic [RES_W-1:0] vin = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int run = 0;
    int last_run = 0;
    int run_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Ideal comparator: at or above the trial level.
    assign cmp_ge = (dac_code <= vin);

    sar_busctl #(
        .RES_W(RES_W), .BUS_W(BUS_W), .ACQ_CYCLES(ACQ), .CAL_CYCLES(CAL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .byte_hi(byte_hi), .reg_sel(reg_sel),
        .cal_hold(cal_hold), .cmp_ge(cmp_ge), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .conv_busy_n(conv_busy_n),
        .dac_code(dac_code)
    );

    // Busy-run monitor, sampled 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            run = 0;
        end else if (conv_busy_n == 1'b0) begin
            if (run == 0) run_cnt = run_cnt + 1;
            run = run + 1;
        end else if (run != 0) begin
            last_run = run;
            run = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic rs, input logic bh, input logic [7:0] d);
        bus_cs_n = 1'b0; reg_sel = rs; byte_hi = bh; data_in = d; bus_wr_n = 1'b0;
        @(negedge clk);
        bus_wr_n = 1'b1;
        @(negedge clk);
        bus_cs_n = 1'b1;
    endtask

    task automatic bus_read(input logic rs, input logic bh,
                            output logic [7:0] d, output logic oe);
        bus_cs_n = 1'b0; reg_sel = rs; byte_hi = bh; bus_rd_n = 1'b0;
        #1;
        d = data_out; oe = data_oe;
        @(negedge clk);
        bus_rd_n = 1'b1; bus_cs_n = 1'b1;
    endtask

    task automatic wait_idle(output int len);
        int g = 0;
        @(negedge clk);
        while (conv_busy_n == 1'b0 && g < 5000) begin
            @(negedge clk);
            g++;
        end
        @(negedge clk);
        len = last_run;
    endtask

    task automatic idle_check(input string tag, input int ncyc, input int runs0);
        repeat (ncyc) @(negedge clk);
        chk({tag, " busy"}, conv_busy_n, 1);
        chk({tag, " runs"}, run_cnt, runs0);
    endtask

    task automatic read_result(output logic [11:0] r);
        logic [7:0] lo, hi;
        logic oe;
        bus_read(1'b0, 1'b0, lo, oe);
        bus_read(1'b0, 1'b1, hi, oe);
        r = {hi[3:0], lo};
    endtask

    // R3 R4 R5: one normal conversion and readback.
    task automatic conv_check(input logic [11:0] v);
        int len;
        logic [7:0] lo, hi;
        logic oe_lo, oe_hi;
        vin = v;
        bus_write(1'b0, 1'b0, 8'h00);
        wait_idle(len);
        chk("R3 conv length", len, NORM_LEN);
        bus_read(1'b0, 1'b0, lo, oe_lo);
        bus_read(1'b0, 1'b1, hi, oe_hi);
        chk("R4 low byte", lo, v & 12'h0FF);
        chk("R5 high byte", hi, v >> 8);
        chk("R5 drive", oe_lo & oe_hi, 1);
    endtask

    initial begin : wdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic oe;
        logic [11:0] r;
        int len;
        int runs0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", conv_busy_n, 1);
        chk("R1 drive", data_oe, 0);
        bus_read(1'b0, 1'b0, d, oe); chk("R1 low byte", d, 0);
        bus_read(1'b0, 1'b1, d, oe); chk("R1 high byte", d, 0);
        bus_read(1'b1, 1'b0, d, oe); chk("R1 ctl", d, 0);

        // R2 deselected strobes
        bus_rd_n = 1'b0; #1;
        chk("R2 drive while deselected", data_oe, 0);
        @(negedge clk); bus_rd_n = 1'b1;
        runs0 = run_cnt;
        reg_sel = 1'b0; bus_wr_n = 1'b0; @(negedge clk); bus_wr_n = 1'b1;
        idle_check("R2 no start", 4, runs0);
        reg_sel = 1'b1; data_in = 8'hFF; bus_wr_n = 1'b0; @(negedge clk); bus_wr_n = 1'b1;
        @(negedge clk);
        idle_check("R2 ctl write", 2, runs0);
        bus_read(1'b1, 1'b0, d, oe); chk("R2 ctl unchanged", d, 0);

        // R3 R4 R5 sweep
        for (int v = 0; v < 4096; v += 3) conv_check(12'(v));
        conv_check(12'hFFF);
        conv_check(12'h7FF);
        conv_check(12'h800);
        conv_check(12'h001);

        // R6 result held during conversion
        conv_check(12'h5A3);
        vin = 12'h123;
        bus_write(1'b0, 1'b0, 8'h00);
        repeat (4) @(negedge clk);
        bus_read(1'b0, 1'b0, d, oe); chk("R6 low byte mid-run", d, 8'hA3);
        repeat (5) @(negedge clk);
        bus_read(1'b0, 1'b1, d, oe); chk("R6 high byte mid-run", d, 8'h05);
        wait_idle(len);
        read_result(r); chk("R6 new result", r, 12'h123);

        // R8 starts while busy are dropped
        vin = 12'h3C7;
        runs0 = run_cnt;
        bus_write(1'b0, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        bus_write(1'b0, 1'b0, 8'h00);
        cal_hold = 1'b1;
        wait_idle(len);
        chk("R8 length", len, NORM_LEN);
        chk("R8 single run", run_cnt, runs0 + 1);
        read_result(r); chk("R8 result", r, 12'h3C7);
        cal_hold = 1'b0;
        idle_check("R8 no retrigger", 4, runs0 + 1);

        // R9 calibration
        vin = 12'h000;
        runs0 = run_cnt;
        cal_hold = 1'b1;
        wait_idle(len);
        chk("R9 cal length", len, CAL);
        chk("R9 one run", run_cnt, runs0 + 1);
        read_result(r); chk("R9 result kept", r, 12'h3C7);
        cal_hold = 1'b0;
        @(negedge clk);

        // R7 control write starts and reads back
        vin = 12'hABC;
        bus_write(1'b1, 1'b0, 8'hA1);
        wait_idle(len);
        chk("R7 length", len, NORM_LEN);
        bus_read(1'b1, 1'b0, d, oe); chk("R7 ctl read", d, 8'hA1);
        read_result(r); chk("R7 result", r, 12'hABC);

        // R10 enter sample/hold mode (start still taken: mode was clear)
        vin = 12'h456;
        bus_write(1'b1, 1'b0, 8'h04);
        wait_idle(len);
        chk("R10 entry write length", len, NORM_LEN);
        bus_read(1'b1, 1'b0, d, oe); chk("R10 ctl", d, 8'h04);
        runs0 = run_cnt;
        bus_write(1'b0, 1'b0, 8'h00);
        idle_check("R10 write ignored", 4, runs0);
        cal_hold = 1'b1;
        idle_check("R10 rise no cal", 4, runs0);
        for (int k = 0; k < 16; k++) begin
            vin = 12'((k * 271 + 5) % 4096);
            cal_hold = 1'b1;
            @(negedge clk);
            cal_hold = 1'b0;
            wait_idle(len);
            chk("R10 hold length", len, RES_W);
            read_result(r); chk("R10 hold result", r, (k * 271 + 5) % 4096);
        end
        runs0 = run_cnt;
        bus_write(1'b1, 1'b0, 8'h00);
        idle_check("R10 exit no start", 4, runs0);
        bus_read(1'b1, 1'b0, d, oe); chk("R10 ctl cleared", d, 0);

        // R11 reserved patterns
        bus_read(1'b1, 1'b1, d, oe);
        chk("R11 rsvd read data", d, 0);
        chk("R11 rsvd read drive", oe, 1);
        runs0 = run_cnt;
        bus_cs_n = 1'b0; reg_sel = 1'b0; byte_hi = 1'b0;
        bus_rd_n = 1'b0; bus_wr_n = 1'b0; #1;
        chk("R11 both strobes data", data_out, 0);
        chk("R11 both strobes drive", data_oe, 1);
        @(negedge clk); bus_wr_n = 1'b1;
        @(negedge clk); bus_rd_n = 1'b1; bus_cs_n = 1'b1;
        idle_check("R11 both strobes no start", 3, runs0);
        bus_write(1'b1, 1'b1, 8'hFF);
        idle_check("R11 rsvd write no start", 3, runs0);
        bus_read(1'b1, 1'b0, d, oe); chk("R11 ctl unchanged", d, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule